// File: doc/BRIEF.md
# IR key lookup with repeat tracking

This block turns a decoded infrared remote frame, given as a 16-bit device code and an 8-bit command code, into a key code. It uses a small table that software loads. The table is split into groups. Each group carries one device code, an entry count and a list of (command, key) pairs. A lookup first picks the group and then walks that group's entries. It finishes with a one-cycle result strobe, a hit flag, the key code and a repeat count. The repeat count tells a held-down button apart from a fresh press.

The table is loaded through a plain write port. With `wrHeader` high, a write sets a group's device code and entry count. With `wrHeader` low, a write sets one (command, key) entry of a group. The search takes one group or one entry per clock, so the table needs no multi-port memory and no wide comparator tree. The host reads `keyCode` and `repeatCnt` straight from output registers. These registers hold their value until the next lookup completes.

Top module: `ir_key_lookup`

## Requirements
- R1: After reset, `keyCode` and `repeatCnt` are 0, `resultValid` and `busy` are low, and every group is invalid, so any lookup misses.
- R2: Groups are examined in index order 0 to 3. The first valid group whose device code equals `devCode` is selected. A later group with the same device code is never consulted.
- R3: Inside the selected group, entries 0 up to count-1 are compared in order, and the first entry whose command equals `cmdCode` gives the key. Entries at or beyond the count are ignored. If the selected group has no matching command, the lookup misses, even when another group holds that command.
- R4: On a hit, `repeatCnt` becomes the previous `repeatCnt` plus one when the new key equals the previously reported `keyCode`. Otherwise `repeatCnt` becomes 0.
- R5: `repeatCnt` (4 bits) saturates at 15 and stays there on further identical hits.
- R6: On a miss, `resultHit` is 0, `keyCode` becomes the reserved value 0 and `repeatCnt` becomes 0.
- R7: A header write (`wrEn` and `wrHeader` high) whose `wrDev` is zero is discarded. The addressed group keeps its previous device code, count and validity. A header write with a nonzero `wrDev` stores it, stores the count and marks the group valid.
- R8: A header count above 16 is stored as 16. A group with count 0 that is selected always misses.
- R9: A `start` pulse in idle latches `devCode` and `cmdCode`, and `busy` is high from the next cycle until the result. A `start` while busy is ignored. `resultValid` is high for exactly one cycle per accepted lookup. `keyCode` and `repeatCnt` do not change between results.
- R10: Let p be the index of the selected group and e the index of the matching entry. A hit raises `resultValid` p+e+2 clocks after the start edge. A miss inside group p with count c raises it p+c+1 clocks after the start edge. A lookup that matches no group raises it 4 clocks after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write strobe |
| wrHeader | input | 1 | 1: write group header, 0: write entry |
| wrGroup | input | 2 | Group addressed by the write |
| wrEntry | input | 4 | Entry index for entry writes |
| wrDev | input | 16 | Device code for header writes |
| wrCount | input | 5 | Entry count for header writes |
| wrCmd | input | 8 | Command code for entry writes |
| wrKey | input | 8 | Key code for entry writes |
| start | input | 1 | Single-cycle lookup request |
| devCode | input | 16 | Device code to look up |
| cmdCode | input | 8 | Command code to look up |
| busy | output | 1 | Lookup in progress |
| resultValid | output | 1 | One-cycle result strobe |
| resultHit | output | 1 | Result was a hit |
| keyCode | output | 8 | Reported key code (0 on miss) |
| repeatCnt | output | 4 | Successive identical-key count |

## Verification
The bench loads two groups with the same device code, so that a design that let the search fall through to the later group would report a key where a miss is due. It places a stored entry just past a group's count, which a design with an off-by-one count compare would hit. It writes a zero device-code header over a live group, which a design without the reject rule would turn into an invalid or resized group. It also drives a count of 17, and runs a lookup that has to walk all 16 entries. It holds one key down long enough to saturate the repeat counter, where a wrapping counter would fall back to 0. It then follows a miss with a hit to check that the counter restarts. It also pulses start while busy, which a design that re-latched would show as a wrong key or an extra strobe, and it times every result against the one-step-per-clock search.

// File: rtl/ir_key_pkg.sv
package ir_key_pkg;

  localparam int unsigned DEF_GROUPS  = 4;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_DEV_W   = 16;
  localparam int unsigned DEF_CMD_W   = 8;
  localparam int unsigned DEF_KEY_W   = 8;
  localparam int unsigned DEF_RPT_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GROUP = 2'd1,
    ST_ENTRY = 2'd2
  } lkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture lookup operands
    logic finish;    // update result registers this edge
    logic hit;       // result is a hit (valid with finish)
  } lkStrobe_t;

endpackage

// File: rtl/ir_key_dp.sv
module ir_key_dp
  import ir_key_pkg::*;
#(
  parameter int NUM_GROUPS  = DEF_GROUPS,
  parameter int MAX_ENTRIES = DEF_ENTRIES,
  parameter int DEV_W       = DEF_DEV_W,
  parameter int CMD_W       = DEF_CMD_W,
  parameter int KEY_W       = DEF_KEY_W,
  parameter int RPT_W       = DEF_RPT_W,
  localparam int GIDX_W     = $clog2(NUM_GROUPS),
  localparam int EIDX_W     = $clog2(MAX_ENTRIES),
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrHeader,
  input  logic [GIDX_W-1:0] wrGroup,
  input  logic [EIDX_W-1:0] wrEntry,
  input  logic [DEV_W-1:0]  wrDev,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic [CMD_W-1:0]  wrCmd,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [DEV_W-1:0]  devCode,
  input  logic [CMD_W-1:0]  cmdCode,
  input  lkStrobe_t         ctl,
  input  logic [GIDX_W-1:0] gIdx,
  input  logic [EIDX_W-1:0] eIdx,
  output logic              grpMatch,
  output logic [CNT_W-1:0]  grpCnt,
  output logic              entMatch,
  output logic              resultValid,
  output logic              resultHit,
  output logic [KEY_W-1:0]  keyCode,
  output logic [RPT_W-1:0]  repeatCnt
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ENTRIES);
  localparam logic [RPT_W-1:0] RPT_MAX = '1;

  logic [DEV_W-1:0] devAt   [NUM_GROUPS];
  logic [CNT_W-1:0] cntAt   [NUM_GROUPS];
  logic             validAt [NUM_GROUPS];
  logic [CMD_W-1:0] cmdAt   [NUM_GROUPS];
  logic [KEY_W-1:0] keyAt   [NUM_GROUPS];

  // one storage slice per group
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_grp
    logic [DEV_W-1:0] devR;
    logic [CNT_W-1:0] cntR;
    logic             validR;
    logic [CMD_W-1:0] cmdR [MAX_ENTRIES];
    logic [KEY_W-1:0] keyR [MAX_ENTRIES];
    logic             hdrWe;
    logic             entWe;

    // a zero device code never reaches the header registers
    assign hdrWe = wrEn && wrHeader && (wrGroup == GIDX_W'(g)) && (wrDev != '0);
    assign entWe = wrEn && !wrHeader && (wrGroup == GIDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        devR   <= '0;
        cntR   <= '0;
        validR <= 1'b0;
      end else if (hdrWe) begin
        devR   <= wrDev;
        cntR   <= (wrCount > MAX_CNT) ? MAX_CNT : wrCount;
        validR <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (entWe) begin
        cmdR[wrEntry] <= wrCmd;
        keyR[wrEntry] <= wrKey;
      end
    end

    assign devAt[g]   = devR;
    assign cntAt[g]   = cntR;
    assign validAt[g] = validR;
    assign cmdAt[g]   = cmdR[eIdx];
    assign keyAt[g]   = keyR[eIdx];
  end

  // latched lookup operands
  logic [DEV_W-1:0] devQ;
  logic [CMD_W-1:0] cmdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devQ <= '0;
      cmdQ <= '0;
    end else if (ctl.latchReq) begin
      devQ <= devCode;
      cmdQ <= cmdCode;
    end
  end

  // single comparator per level, indexed by the control counters
  logic [KEY_W-1:0] entKey;
  assign grpMatch = validAt[gIdx] && (devAt[gIdx] == devQ);
  assign grpCnt   = cntAt[gIdx];
  assign entMatch = (cmdAt[gIdx] == cmdQ);
  assign entKey   = keyAt[gIdx];

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultHit   <= 1'b0;
      keyCode     <= '0;
      repeatCnt   <= '0;
    end else begin
      resultValid <= ctl.finish;
      if (ctl.finish) begin
        resultHit <= ctl.hit;
        if (ctl.hit) begin
          keyCode <= entKey;
          if (entKey == keyCode) begin
            repeatCnt <= (repeatCnt == RPT_MAX) ? RPT_MAX : repeatCnt + RPT_W'(1);
          end else begin
            repeatCnt <= '0;
          end
        end else begin
          keyCode   <= '0;
          repeatCnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/ir_key_ctrl.sv
module ir_key_ctrl
  import ir_key_pkg::*;
#(
  parameter int NUM_GROUPS  = DEF_GROUPS,
  parameter int MAX_ENTRIES = DEF_ENTRIES,
  localparam int GIDX_W     = $clog2(NUM_GROUPS),
  localparam int EIDX_W     = $clog2(MAX_ENTRIES),
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              grpMatch,
  input  logic [CNT_W-1:0]  grpCnt,
  input  logic              entMatch,
  output lkStrobe_t         ctl,
  output logic [GIDX_W-1:0] gIdx,
  output logic [EIDX_W-1:0] eIdx,
  output logic              busy
);

  localparam logic [GIDX_W-1:0] LAST_G = GIDX_W'(NUM_GROUPS - 1);

  lkState_e          st, stN;
  logic [GIDX_W-1:0] gN;
  logic [EIDX_W-1:0] eN;
  logic              lastEnt;

  assign lastEnt = (CNT_W'(eIdx) + CNT_W'(1)) == grpCnt;

  always_comb begin
    stN = st;
    gN  = gIdx;
    eN  = eIdx;
    ctl = '0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          ctl.latchReq = 1'b1;
          stN          = ST_GROUP;
          gN           = '0;
        end
      end
      ST_GROUP: begin
        if (grpMatch) begin
          if (grpCnt == '0) begin
            ctl.finish = 1'b1;
            stN        = ST_IDLE;
          end else begin
            stN = ST_ENTRY;
            eN  = '0;
          end
        end else if (gIdx == LAST_G) begin
          ctl.finish = 1'b1;
          stN        = ST_IDLE;
        end else begin
          gN = gIdx + GIDX_W'(1);
        end
      end
      ST_ENTRY: begin
        if (entMatch) begin
          ctl.finish = 1'b1;
          ctl.hit    = 1'b1;
          stN        = ST_IDLE;
        end else if (lastEnt) begin
          ctl.finish = 1'b1;
          stN        = ST_IDLE;
        end else begin
          eN = eIdx + EIDX_W'(1);
        end
      end
      default: stN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      gIdx <= '0;
      eIdx <= '0;
    end else begin
      st   <= stN;
      gIdx <= gN;
      eIdx <= eN;
    end
  end

  assign busy = (st != ST_IDLE);

endmodule

// File: rtl/ir_key_lookup.sv
module ir_key_lookup
  import ir_key_pkg::*;
#(
  parameter int NUM_GROUPS  = DEF_GROUPS,
  parameter int MAX_ENTRIES = DEF_ENTRIES,
  parameter int DEV_W       = DEF_DEV_W,
  parameter int CMD_W       = DEF_CMD_W,
  parameter int KEY_W       = DEF_KEY_W,
  parameter int RPT_W       = DEF_RPT_W,
  localparam int GIDX_W     = $clog2(NUM_GROUPS),
  localparam int EIDX_W     = $clog2(MAX_ENTRIES),
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrHeader,
  input  logic [GIDX_W-1:0] wrGroup,
  input  logic [EIDX_W-1:0] wrEntry,
  input  logic [DEV_W-1:0]  wrDev,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic [CMD_W-1:0]  wrCmd,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic              start,
  input  logic [DEV_W-1:0]  devCode,
  input  logic [CMD_W-1:0]  cmdCode,
  output logic              busy,
  output logic              resultValid,
  output logic              resultHit,
  output logic [KEY_W-1:0]  keyCode,
  output logic [RPT_W-1:0]  repeatCnt
);

  lkStrobe_t         ctl;
  logic [GIDX_W-1:0] gIdx;
  logic [EIDX_W-1:0] eIdx;
  logic              grpMatch;
  logic              entMatch;
  logic [CNT_W-1:0]  grpCnt;

  ir_key_ctrl #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_ENTRIES(MAX_ENTRIES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .grpMatch(grpMatch),
    .grpCnt  (grpCnt),
    .entMatch(entMatch),
    .ctl     (ctl),
    .gIdx    (gIdx),
    .eIdx    (eIdx),
    .busy    (busy)
  );

  ir_key_dp #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_ENTRIES(MAX_ENTRIES),
    .DEV_W      (DEV_W),
    .CMD_W      (CMD_W),
    .KEY_W      (KEY_W),
    .RPT_W      (RPT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrHeader   (wrHeader),
    .wrGroup    (wrGroup),
    .wrEntry    (wrEntry),
    .wrDev      (wrDev),
    .wrCount    (wrCount),
    .wrCmd      (wrCmd),
    .wrKey      (wrKey),
    .devCode    (devCode),
    .cmdCode    (cmdCode),
    .ctl        (ctl),
    .gIdx       (gIdx),
    .eIdx       (eIdx),
    .grpMatch   (grpMatch),
    .grpCnt     (grpCnt),
    .entMatch   (entMatch),
    .resultValid(resultValid),
    .resultHit  (resultHit),
    .keyCode    (keyCode),
    .repeatCnt  (repeatCnt)
  );

endmodule

// File: rtl/ir_key_checker.sv
module ir_key_checker #(
  parameter int KEY_W = 8,
  parameter int RPT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             resultValid,
  input logic             resultHit,
  input logic [KEY_W-1:0] keyCode,
  input logic [RPT_W-1:0] repeatCnt
);

  localparam logic [RPT_W-1:0] RPT_MAX = '1;

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r9_result_from_busy: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(busy));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(keyCode) && $stable(repeatCnt)));

  a_r6_miss_clears: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !resultHit) |-> (keyCode == '0 && repeatCnt == '0));

  a_r4_repeat_step: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultHit && keyCode == $past(keyCode) && $past(repeatCnt) != RPT_MAX)
      |-> (repeatCnt == $past(repeatCnt) + RPT_W'(1)));

  a_r4_new_key_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultHit && keyCode != $past(keyCode)) |-> (repeatCnt == '0));

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultHit && keyCode == $past(keyCode) && $past(repeatCnt) == RPT_MAX)
      |-> (repeatCnt == RPT_MAX));

endmodule

bind ir_key_lookup ir_key_checker #(
  .KEY_W(KEY_W),
  .RPT_W(RPT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .resultValid(resultValid),
  .resultHit  (resultHit),
  .keyCode    (keyCode),
  .repeatCnt  (repeatCnt)
);

// File: tb/ir_key_lookup_bench.sv
module ir_key_lookup_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrHeader = 1'b0;
  logic [1:0]  wrGroup = '0;
  logic [3:0]  wrEntry = '0;
  logic [15:0] wrDev = '0;
  logic [4:0]  wrCount = '0;
  logic [7:0]  wrCmd = '0;
  logic [7:0]  wrKey = '0;
  logic        start = 1'b0;
  logic [15:0] devCode = '0;
  logic [7:0]  cmdCode = '0;
  logic        busy;
  logic        resultValid;
  logic        resultHit;
  logic [7:0]  keyCode;
  logic [3:0]  repeatCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_key_lookup u_ir_key_lookup (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrHeader(wrHeader), .wrGroup(wrGroup), .wrEntry(wrEntry),
    .wrDev(wrDev), .wrCount(wrCount), .wrCmd(wrCmd), .wrKey(wrKey),
    .start(start), .devCode(devCode), .cmdCode(cmdCode),
    .busy(busy), .resultValid(resultValid), .resultHit(resultHit),
    .keyCode(keyCode), .repeatCnt(repeatCnt)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sCyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference table built from the requirements
  int mDev [NG];
  int mCnt [NG];
  bit mVal [NG];
  int mCmd [NG][NE];
  int mKey [NG][NE];
  int lastKey = 0;
  int lastRep = 0;

  typedef struct {
    int    key;
    int    rep;
    bit    hit;
    int    lat;
    string tag;
  } exp_t;
  exp_t q[$];

  int seenKey = 0;
  int seenRep = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wrHdr(input int g, input int dev, input int cnt);
    @(negedge clk);
    wrEn = 1'b1; wrHeader = 1'b1; wrGroup = 2'(g); wrDev = 16'(dev); wrCount = 5'(cnt);
    @(negedge clk);
    wrEn = 1'b0;
    if (dev != 0) begin
      mDev[g] = dev;
      mCnt[g] = (cnt > NE) ? NE : cnt;
      mVal[g] = 1'b1;
    end
  endtask

  task automatic wrEnt(input int g, input int e, input int cmd, input int key);
    @(negedge clk);
    wrEn = 1'b1; wrHeader = 1'b0; wrGroup = 2'(g); wrEntry = 4'(e);
    wrCmd = 8'(cmd); wrKey = 8'(key);
    @(negedge clk);
    wrEn = 1'b0;
    mCmd[g][e] = cmd;
    mKey[g][e] = key;
  endtask

  // computes the expected result and pushes it
  task automatic predict(input int d, input int c, input string tag);
    exp_t x;
    int p;
    p = -1;
    x.hit = 1'b0; x.key = 0; x.rep = 0; x.tag = tag;
    for (int g = 0; g < NG; g++) begin
      if (p < 0 && mVal[g] && mDev[g] == d) p = g;
    end
    if (p < 0) begin
      x.lat = NG + 1;
    end else begin
      x.lat = p + mCnt[p] + 2;
      for (int e = 0; e < NE; e++) begin
        if (!x.hit && e < mCnt[p] && mCmd[p][e] == c) begin
          x.hit = 1'b1;
          x.key = mKey[p][e];
          x.lat = p + e + 3;
        end
      end
    end
    if (x.hit) begin
      x.rep = (x.key == lastKey) ? ((lastRep == 15) ? 15 : lastRep + 1) : 0;
    end
    lastKey = x.key;
    lastRep = x.rep;
    q.push_back(x);
  endtask

  task automatic waitDrain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lookup(input int d, input int c, input string tag);
    predict(d, c, tag);
    @(negedge clk);
    devCode = 16'(d); cmdCode = 8'(c); start = 1'b1; sCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (q[0].lat > 2) chk(busy == 1'b1, {tag, " R9 busy after start"}, int'(busy), 1);
    waitDrain();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (resultValid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected result strobe", 1, 0);
        end else begin
          exp_t x;
          x = q.pop_front();
          chk(resultHit == x.hit, {x.tag, " hit"}, int'(resultHit), int'(x.hit));
          chk(int'(keyCode) == x.key, {x.tag, " key"}, int'(keyCode), x.key);
          chk(int'(repeatCnt) == x.rep, {x.tag, " repeat"}, int'(repeatCnt), x.rep);
          chk(cyc - sCyc == x.lat, {x.tag, " R10 latency"}, cyc - sCyc, x.lat);
        end
        seenKey = int'(keyCode);
        seenRep = int'(repeatCnt);
      end else begin
        chk(int'(keyCode) == seenKey && int'(repeatCnt) == seenRep,
            "R9 outputs held between results", int'(keyCode), seenKey);
      end
    end
  end

  task automatic finishRun();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      mVal[g] = 1'b0; mDev[g] = 0; mCnt[g] = 0;
      for (int e = 0; e < NE; e++) begin mCmd[g][e] = -1; mKey[g][e] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(keyCode == 8'd0, "R1 reset keyCode", int'(keyCode), 0);
    chk(repeatCnt == 4'd0, "R1 reset repeatCnt", int'(repeatCnt), 0);
    chk(resultValid == 1'b0, "R1 reset resultValid", int'(resultValid), 0);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);

    lookup(16'h0000, 8'h00, "R1 empty table zero code");
    lookup(16'h10EF, 8'h01, "R1 empty table");

    // group 0: three live entries, one stored beyond the count
    wrHdr(0, 16'h10EF, 3);
    wrEnt(0, 0, 8'h01, 8'h21);
    wrEnt(0, 1, 8'h02, 8'h22);
    wrEnt(0, 2, 8'h03, 8'h23);
    wrEnt(0, 3, 8'h04, 8'h24);
    // group 1: count 17 clamps to 16
    wrHdr(1, 16'h20DF, 17);
    for (int e = 0; e < NE; e++) wrEnt(1, e, 8'h40 + e, 8'h60 + e);
    // group 2 duplicates group 0's device code
    wrHdr(2, 16'h10EF, 1);
    wrEnt(2, 0, 8'h05, 8'h77);
    // group 3: valid but empty
    wrHdr(3, 16'h3344, 0);
    // zero device code over group 0 must be discarded
    wrHdr(0, 16'h0000, 5);

    lookup(16'h10EF, 8'h02, "R3 first-match hit");
    lookup(16'h10EF, 8'h02, "R4 repeat one");
    lookup(16'h10EF, 8'h02, "R4 repeat two");
    lookup(16'h10EF, 8'h03, "R4 new key resets");
    lookup(16'h10EF, 8'h04, "R3 R7 entry beyond count");
    lookup(16'h10EF, 8'h05, "R2 later duplicate group unused");
    lookup(16'h10EF, 8'h01, "R7 group kept after zero header");
    lookup(16'h20DF, 8'h40, "R2 second group hit");
    lookup(16'h20DF, 8'h4F, "R8 clamp last entry");
    for (int i = 0; i < 17; i++) lookup(16'h20DF, 8'h4F, "R5 saturation run");
    lookup(16'h3344, 8'h01, "R8 count zero miss");
    lookup(16'h5555, 8'h02, "R6 unknown device miss");
    lookup(16'h10EF, 8'h02, "R6 hit after miss restarts");
    lookup(16'h10EF, 8'h02, "R4 repeat after restart");
    lookup(16'h0000, 8'h02, "R7 zero code never valid");

    // start while busy must be ignored
    predict(16'h20DF, 8'h4A, "R9 busy start ignored");
    @(negedge clk);
    devCode = 16'h20DF; cmdCode = 8'h4A; start = 1'b1; sCyc = cyc;
    @(negedge clk);
    devCode = 16'h10EF; cmdCode = 8'h01;
    @(negedge clk);
    start = 1'b0;
    waitDrain();
    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R9 no extra lookup", q.size(), 0);

    finishRun();
  end

endmodule